// File: doc/BRIEF.md
# Ring Routing Direction Selector

This block sits at the injection point of one node on an eight-node bidirectional ring. For each request it is given a source and a destination node index. It decides whether the packet leaves on the clockwise or the counterclockwise channel, or whether the packet is for the node itself and never enters the ring. A request picks one of four policies:
- greedy shortest path,
- a fair coin,
- a coin weighted by distance,
- load-adaptive choice.

The adaptive policy compares a load figure for each outgoing channel. That figure is either a queue occupancy supplied from outside, or the number of packets this block sent on that channel over the last T cycles. The sent counts are kept in an internal shift history for each direction.

A small sequencer with two named states controls the result timing. In `ST_IDLE` no result is presented. In `ST_ISSUE` a registered result is shown for exactly one cycle.

The transitions are:
- `ST_IDLE -> ST_ISSUE` on an accepted request.
- `ST_ISSUE -> ST_ISSUE` on a back-to-back request.
- `ST_ISSUE -> ST_IDLE` when no request arrives.

Random choices come from an internal 16-bit linear feedback shift register. It moves one step for each accepted request.

Top module: `ring_dir_sel`

## Requirements
- R1: The clockwise distance is (dst - src) mod 8 and the counterclockwise distance is (src - dst) mod 8. The shorter of the two is the minimum distance D.
- R2: With req_mode = 0 (greedy), a request whose two distances differ leaves on the shorter side. out_dir = 0 means clockwise and 1 means counterclockwise. For example, every request of the pattern i to (i+3) mod 8 gives out_dir = 0.
- R3: In greedy mode with D = 4, out_dir equals bit 0 of the random state.
- R4: With req_mode = 1 (uniform), out_dir equals bit 0 of the random state, whatever the distance.
- R5: With req_mode = 2 (weighted), r is bits [2:0] of the random state. The short side is clockwise when the clockwise distance is less than or equal to the counterclockwise distance, and counterclockwise otherwise. The long side is chosen when r < D, and the short side otherwise.
- R6: With req_mode = 3 (adaptive), the side whose load figure is strictly smaller is chosen. With load_sel = 0 the figures are load_cw_i and load_ccw_i.
- R7: In adaptive mode with equal load figures, the result is what greedy mode would give for the same request, including the random tie rule.
- R8: With load_sel = 1, each side's load figure is the number of cycles among the last T (default 16) in which out_valid was high with that direction and out_local low. Reset clears both histories.
- R9: The random state is a 16-bit shift register with feedback s[15]^s[13]^s[12]^s[10] shifted into bit 0, and reset seed 0xACE1. Each request reads the state first, and then the state advances once per accepted request, local requests included.
- R10: When src equals dst, the result has out_local = 1 and out_dir = 0, and it adds nothing to either history.
- R11: out_valid is high exactly in the cycle after a cycle with req_valid high, and it is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_src | input | 3 | Source node index |
| req_dst | input | 3 | Destination node index |
| req_mode | input | 2 | Policy: 0 greedy, 1 uniform, 2 weighted, 3 adaptive |
| load_sel | input | 1 | Adaptive load figure: 0 external queue, 1 sent history |
| load_cw_i | input | 8 | Queue occupancy feeding the clockwise channel |
| load_ccw_i | input | 8 | Queue occupancy feeding the counterclockwise channel |
| out_valid | output | 1 | Registered result valid |
| out_dir | output | 1 | Registered direction, 0 clockwise, 1 counterclockwise |
| out_local | output | 1 | Registered local-delivery flag |

## Verification
The bench drives the tornado pattern and the distance-four ties. A selector that rounded ties toward one side, or computed the distance without wrap-around, would send some packets the long way or ignore the random bit. Weighted requests are issued at every distance from one to four; an off-by-one in the r < D comparison would flip the side for a single value of r. The adaptive tests put the queue inputs and the sent history in conflict, so a design that read the wrong figure, forgot to clear history at reset, or never aged old sends out of the window would choose the opposite side. Local requests check that the random source still advances, since a skipped step would shift every later random choice.

// File: rtl/ring_dir_pkg.sv
package ring_dir_pkg;

    typedef enum logic [1:0] {
        POL_GREEDY   = 2'd0,
        POL_UNIFORM  = 2'd1,
        POL_WEIGHTED = 2'd2,
        POL_ADAPTIVE = 2'd3
    } policy_e;

    typedef enum logic {
        DIR_CW  = 1'b0,
        DIR_CCW = 1'b1
    } dir_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } seq_state_e;

    localparam int NUM_DIRS = 2;

endpackage

// File: rtl/ring_dist_calc.sv
module ring_dist_calc #(
    parameter int NODE_W = 3
) (
    input  logic [NODE_W-1:0] src_i,
    input  logic [NODE_W-1:0] dst_i,
    output logic [NODE_W-1:0] cw_dist_o,
    output logic [NODE_W-1:0] min_dist_o,
    output logic              short_is_cw_o,
    output logic              tie_o,
    output logic              is_local_o
);
    logic [NODE_W-1:0] ccw_dist;

    // Modular subtraction wraps naturally on NODE_W bits.
    always_comb begin
        cw_dist_o     = dst_i - src_i;
        ccw_dist      = src_i - dst_i;
        short_is_cw_o = (cw_dist_o <= ccw_dist);
        tie_o         = (cw_dist_o == ccw_dist) && (cw_dist_o != '0);
        is_local_o    = (cw_dist_o == '0);
        min_dist_o    = short_is_cw_o ? cw_dist_o : ccw_dist;
    end

endmodule

// File: rtl/ring_lfsr.sv
module ring_lfsr #(
    parameter logic [15:0] SEED  = 16'hACE1,
    parameter int          RND_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance_i,
    output logic [RND_W-1:0] rnd_o
);
    logic [15:0] state;
    logic        feedback;

    always_comb begin
        feedback = state[15] ^ state[13] ^ state[12] ^ state[10];
        rnd_o    = state[RND_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else if (advance_i) begin
            state <= {state[14:0], feedback};
        end
    end

    assert_lfsr_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state != 16'h0000);

    assert_lfsr_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !advance_i |=> $stable(state));

endmodule

// File: rtl/ring_tx_history.sv
module ring_tx_history #(
    parameter int HIST_T = 16,
    parameter int CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sent_i,
    output logic [CNT_W-1:0] count_o
);
    logic [HIST_T-1:0] hist;
    logic              armed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist  <= '0;
            armed <= 1'b0;
        end else begin
            hist  <= {hist[HIST_T-2:0], sent_i};
            armed <= 1'b1;
        end
    end

    always_comb begin
        count_o = '0;
        for (int i = 0; i < HIST_T; i++) begin
            count_o = count_o + CNT_W'(hist[i]);
        end
    end

    // One slot enters and one leaves per cycle, so the count moves by at most one.
    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> ((CNT_W+1)'(count_o) <= (CNT_W+1)'($past(count_o)) + 1'b1) &&
                  ((CNT_W+1)'($past(count_o)) <= (CNT_W+1)'(count_o) + 1'b1));

    assert_count_zero_after_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> count_o == '0);

endmodule

// File: rtl/ring_dir_sel.sv
module ring_dir_sel
    import ring_dir_pkg::*;
#(
    parameter int          NODE_W = 3,
    parameter int          LOAD_W = 8,
    parameter int          HIST_T = 16,
    parameter logic [15:0] SEED   = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [NODE_W-1:0] req_src,
    input  logic [NODE_W-1:0] req_dst,
    input  logic [1:0]        req_mode,
    input  logic              load_sel,
    input  logic [LOAD_W-1:0] load_cw_i,
    input  logic [LOAD_W-1:0] load_ccw_i,
    output logic              out_valid,
    output logic              out_dir,
    output logic              out_local
);
    localparam int CNT_W = $clog2(HIST_T + 1);
    localparam int CMP_W = (LOAD_W > CNT_W) ? LOAD_W : CNT_W;

    // Distance
    logic [NODE_W-1:0] cw_dist, min_dist;
    logic              short_is_cw, dist_tie, is_local;

    ring_dist_calc #(.NODE_W(NODE_W)) u_dist (
        .src_i         (req_src),
        .dst_i         (req_dst),
        .cw_dist_o     (cw_dist),
        .min_dist_o    (min_dist),
        .short_is_cw_o (short_is_cw),
        .tie_o         (dist_tie),
        .is_local_o    (is_local)
    );

    // Random source
    logic [NODE_W-1:0] rnd;

    ring_lfsr #(.SEED(SEED), .RND_W(NODE_W)) u_lfsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (req_valid),
        .rnd_o     (rnd)
    );

    // Sent histories, one per direction
    logic [NUM_DIRS-1:0] sent_bit;
    logic [CNT_W-1:0]    hist_cnt [NUM_DIRS];

    always_comb begin
        sent_bit[DIR_CW]  = out_valid && !out_local && (out_dir == DIR_CW);
        sent_bit[DIR_CCW] = out_valid && !out_local && (out_dir == DIR_CCW);
    end

    for (genvar d = 0; d < NUM_DIRS; d++) begin : g_hist
        ring_tx_history #(.HIST_T(HIST_T), .CNT_W(CNT_W)) u_hist (
            .clk     (clk),
            .rst_n   (rst_n),
            .sent_i  (sent_bit[d]),
            .count_o (hist_cnt[d])
        );
    end

    // Decision
    logic [CMP_W-1:0] eff_cw, eff_ccw;
    dir_e             short_dir, greedy_dir, pick_dir;
    policy_e          policy;

    always_comb begin
        policy  = policy_e'(req_mode);
        eff_cw  = load_sel ? CMP_W'(hist_cnt[DIR_CW])  : CMP_W'(load_cw_i);
        eff_ccw = load_sel ? CMP_W'(hist_cnt[DIR_CCW]) : CMP_W'(load_ccw_i);

        short_dir  = short_is_cw ? DIR_CW : DIR_CCW;
        greedy_dir = dist_tie ? dir_e'(rnd[0]) : short_dir;

        unique case (policy)
            POL_GREEDY:   pick_dir = greedy_dir;
            POL_UNIFORM:  pick_dir = dir_e'(rnd[0]);
            POL_WEIGHTED: pick_dir = (rnd < min_dist) ? dir_e'(~short_dir) : short_dir;
            POL_ADAPTIVE: begin
                if (eff_cw < eff_ccw)      pick_dir = DIR_CW;
                else if (eff_ccw < eff_cw) pick_dir = DIR_CCW;
                else                       pick_dir = greedy_dir;
            end
            default:      pick_dir = greedy_dir;
        endcase

        if (is_local) pick_dir = DIR_CW;
    end

    // Sequencer: state register
    seq_state_e state_q, state_d;

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = req_valid ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_d = req_valid ? ST_ISSUE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Sequencer: outputs
    logic dir_q, local_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= 1'b0;
            local_q <= 1'b0;
        end else if (req_valid) begin
            dir_q   <= pick_dir;
            local_q <= is_local;
        end
    end

    assign out_valid = (state_q == ST_ISSUE);
    assign out_dir   = dir_q;
    assign out_local = local_q;

    assert_valid_after_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    assert_idle_after_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    assert_greedy_short_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'd0 && !is_local && !dist_tie)
            |=> out_dir == $past(!short_is_cw));

    assert_local_cw_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src == req_dst) |=> (out_local && out_dir == 1'b0));

    assert_tornado_cw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 2'd0 && cw_dist == NODE_W'(3)) |=> !out_dir);

endmodule

// File: tb/ring_dir_sel_test.sv
module ring_dir_sel_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_src = '0, req_dst = '0;
    logic [1:0] req_mode = '0;
    logic       load_sel = 1'b0;
    logic [7:0] load_cw_i = '0, load_ccw_i = '0;
    logic       out_valid, out_dir, out_local;

    always #2.5 clk = ~clk;

    ring_dir_sel uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_src(req_src), .req_dst(req_dst), .req_mode(req_mode),
        .load_sel(load_sel), .load_cw_i(load_cw_i), .load_ccw_i(load_ccw_i),
        .out_valid(out_valid), .out_dir(out_dir), .out_local(out_local)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] rng = 16'hACE1;

    logic [1:0] exp_q [$];
    string      tag_q [$];

    function automatic logic [1:0] model(int s, int d, int mode, int lcw, int lccw,
                                         logic [15:0] st);
        int cw, ccw, delta;
        logic sdir, gdir, dir;
        cw  = (d - s + 8) % 8;
        ccw = (s - d + 8) % 8;
        if (cw == 0) return 2'b10;
        delta = (cw <= ccw) ? cw : ccw;
        sdir  = (cw <= ccw) ? 1'b0 : 1'b1;
        gdir  = (cw == ccw) ? st[0] : sdir;
        case (mode)
            0: dir = gdir;
            1: dir = st[0];
            2: dir = (int'(st[2:0]) < delta) ? ~sdir : sdir;
            default: dir = (lcw < lccw) ? 1'b0 : (lcw > lccw) ? 1'b1 : gdir;
        endcase
        return {1'b0, dir};
    endfunction

    task automatic issue(input int s, input int d, input int mode, input bit lsel,
                         input int qcw, input int qccw, input int mcw, input int mccw,
                         input string tag);
        int ecw, eccw;
        ecw  = lsel ? mcw  : qcw;
        eccw = lsel ? mccw : qccw;
        exp_q.push_back(model(s, d, mode, ecw, eccw, rng));
        tag_q.push_back(tag);
        rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
        req_valid  = 1'b1;
        req_src    = 3'(s);
        req_dst    = 3'(d);
        req_mode   = 2'(mode);
        load_sel   = lsel;
        load_cw_i  = 8'(qcw);
        load_ccw_i = 8'(qccw);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R11 unexpected result actual=valid expected=idle");
            end else begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({out_local, out_dir} != e) begin
                    errors++;
                    $display("FAIL %s local/dir actual=%b%b expected=%b", t,
                             out_local, out_dir, e);
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_local !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset state actual=%b%b expected=00", out_valid, out_local);
        end

        // R8: histories empty after reset; queue inputs would say ccw
        issue(0, 3, 3, 1, 9, 0, 0, 0, "R8 cleared");
        idle(2);

        // R2: tornado pattern
        for (int i = 0; i < 8; i++) issue(i, (i + 3) % 8, 0, 0, 0, 0, 0, 0, "R2 tornado");
        idle(1);

        // R1: distances with wrap-around
        issue(0, 5, 0, 0, 0, 0, 0, 0, "R1 0to5");
        issue(2, 1, 0, 0, 0, 0, 0, 0, "R1 2to1");
        issue(6, 0, 0, 0, 0, 0, 0, 0, "R1 6to0");
        issue(7, 4, 0, 0, 0, 0, 0, 0, "R1 7to4");

        // R3: greedy ties
        issue(0, 4, 0, 0, 0, 0, 0, 0, "R3 tie");
        issue(1, 5, 0, 0, 0, 0, 0, 0, "R3 tie");
        issue(3, 7, 0, 0, 0, 0, 0, 0, "R3 tie");
        issue(5, 1, 0, 0, 0, 0, 0, 0, "R3 tie");
        idle(3);

        // R4: uniform
        for (int i = 0; i < 6; i++) issue(i, (i + 1) % 8, 1, 0, 0, 0, 0, 0, "R4 uniform");

        // R5: weighted at every distance
        for (int d = 1; d <= 4; d++)
            for (int k = 0; k < 3; k++)
                issue(1, (1 + d) % 8, 2, 0, 0, 0, 0, 0, "R5 weighted");
        issue(4, 1, 2, 0, 0, 0, 0, 0, "R5 weighted ccw-short");
        issue(4, 2, 2, 0, 0, 0, 0, 0, "R5 weighted ccw-short");

        // R10 / R9: local requests still consume a random step
        issue(3, 3, 0, 0, 0, 0, 0, 0, "R10 local");
        issue(6, 6, 3, 0, 0, 5, 0, 0, "R10 local");
        issue(0, 4, 1, 0, 0, 0, 0, 0, "R9 after local");
        idle(2);

        // R6 / R7: adaptive with queue figures
        issue(0, 3, 3, 0, 5, 2, 0, 0, "R6 ccw lighter");
        issue(0, 5, 3, 0, 1, 7, 0, 0, "R6 cw lighter");
        issue(0, 1, 3, 0, 255, 254, 0, 0, "R6 wide load");
        issue(0, 3, 3, 0, 4, 4, 0, 0, "R7 equal short");
        issue(0, 6, 3, 0, 4, 4, 0, 0, "R7 equal short");
        issue(0, 4, 3, 0, 9, 9, 0, 0, "R7 equal tie");
        issue(2, 6, 3, 0, 0, 0, 0, 0, "R7 equal tie");

        // R8: windowed sent history
        idle(20);
        for (int i = 0; i < 3; i++) issue(0, 1, 0, 0, 0, 0, 0, 0, "R8 fill cw");
        issue(0, 4, 3, 1, 0, 9, 2, 0, "R8 cw busy");
        idle(20);
        for (int i = 0; i < 3; i++) issue(0, 5, 0, 0, 0, 0, 0, 0, "R8 fill ccw");
        issue(0, 5, 3, 1, 9, 0, 0, 2, "R8 ccw busy");
        idle(20);
        issue(0, 5, 3, 1, 9, 0, 0, 0, "R8 window aged");
        idle(4);

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R11 missing results actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule